// File: doc/BRIEF.md
# Configuration Register Bank with Nonvolatile Save

This block holds the configuration bytes of a clock-generator core behind a plain byte-wide write port and a combinational read port, with sixteen addresses. Six of those bytes (addresses 1 to 6) are volatile working registers. An internal nonvolatile image holds a saved copy of them. After each reset release the working registers reload from that image. A blank image carries a fixed set of factory values.

Software saves the working registers by writing a 1 to the save bit. A three-state controller then runs a programming window of `PROG_CYCLES` clock cycles. During that window the busy flag is shown and every write is dropped. At the end of the window the image takes the working values, with the power-down bit forced to 0. A lock bit can be set but never cleared. Once a save has stored the lock bit in the image, no further save starts.

The controller has three states. LOAD: the one cycle after reset release, when the image is copied into the working registers and writes are dropped. IDLE: normal operation, when writes apply. PROG: the programming window. Its transitions are: reset → LOAD; LOAD → IDLE, always; IDLE → PROG, on an accepted save request; PROG → IDLE, when the window counter reaches zero, which commits the image.

Top module: `cfgnv_bank`

## Requirements
- R1: Address 0 is read-only and reads {VARIANT, REVISION[2:0], 4'h1}. Writes to it change nothing.
- R2: After the image is blanked and reset is released, addresses 1..6 read 00h, B4h, 01h, 02h, 50h, A0h, and `blk_count` reads 50h.
- R3: These read as 0 whatever is written: address 1 bit 7, address 5 bits 2:0, address 6 bit 0, and every address from 7 to 15.
- R4: A write of 1 to address 6 bit 0 in IDLE, with `locked` low, starts a save. `busy` and address 1 bit 6 read 1 from the next cycle for exactly `PROG_CYCLES` cycles, then read 0.
- R5: While `busy` is 1, every write is ignored, including another save request.
- R6: A completed save stores addresses 1..6. After a later reset pulse, those addresses read back the stored values.
- R7: Address 1 bit 4 drives `pwrdn` directly. The image always stores this bit as 0, so it reads 0 after a reload.
- R8: Writing 1 to address 1 bit 5 sets the lock bit, and writing 0 does not clear it. A save stores the bit. Once it is stored, `locked` is 1, save requests are rejected (`busy` stays 0), and the bit survives reset.
- R9: `blk_count` equals address 6 bits 7:1. Writes to address 6 in IDLE update it.
- R10: The cycle after reset release is the LOAD cycle. It copies the image into the registers, and a write presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the working registers and controller |
| nv_blank_n | input | 1 | Synchronous active-low return of the nonvolatile image to factory values |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Read data, combinational |
| busy | output | 1 | Programming window active |
| locked | output | 1 | Lock bit held in the image |
| pwrdn | output | 1 | Power-down control |
| blk_count | output | 7 | Byte count for block reads |

## Verification
A controller stuck in PROG shows up as `busy` staying high beyond `PROG_CYCLES` cycles, and the window-length check catches it on the next cycle. A missed or wrong commit stays hidden until the next reset pulse: the reloaded bytes, the `pwrdn` level and the `locked` output then differ from what was written before the save. A lock bit that can be cleared, or a write path left open during busy, shows at once in a read or in `blk_count` on the cycle after the write.

// File: rtl/cfgnv_pkg.sv
package cfgnv_pkg;

    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned NV_BYTES = 6;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_IDLE = 2'd1,
        ST_PROG = 2'd2
    } nv_state_t;

    localparam logic [ADDR_W-1:0] A_ID   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd1;
    localparam logic [ADDR_W-1:0] A_OUT1 = 4'd2;
    localparam logic [ADDR_W-1:0] A_DIVL = 4'd3;
    localparam logic [ADDR_W-1:0] A_SEL  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAP  = 4'd5;
    localparam logic [ADDR_W-1:0] A_BCNT = 4'd6;

    localparam int unsigned BUSY_BIT = 6;
    localparam int unsigned LOCK_BIT = 5;
    localparam int unsigned PWDN_BIT = 4;
    localparam int unsigned SAVE_BIT = 0;

    // factory contents of a blank image, index i is address i+1
    function automatic byte_t nv_default(int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'hB4;
            2:       return 8'h01;
            3:       return 8'h02;
            4:       return 8'h50;
            5:       return 8'hA0;
            default: return 8'h00;
        endcase
    endfunction

    // bits a plain write replaces (lock bit handled apart)
    function automatic byte_t wr_mask(int idx);
        case (idx)
            0:       return 8'h1F;
            4:       return 8'hF8;
            5:       return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

    // bits that a write can only set
    function automatic byte_t sticky_mask(int idx);
        return (idx == 0) ? 8'h20 : 8'h00;
    endfunction

    // bits the image keeps on commit; power-down never stored
    function automatic byte_t store_mask(int idx);
        case (idx)
            0:       return 8'h2F;
            4:       return 8'hF8;
            5:       return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgnv_fsm.sv
module cfgnv_fsm
    import cfgnv_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              save_bit,
    input  logic              nv_locked,
    output logic              load,
    output logic              wr_ok,
    output logic              busy,
    output logic              commit
);

    localparam int unsigned CW = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);

    nv_state_t      state, state_nxt;
    logic [CW-1:0]  cnt;
    logic           save_go;
    logic           cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign save_go  = (state == ST_IDLE) && wr_en && (wr_addr == A_BCNT)
                      && save_bit && !nv_locked;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOAD: state_nxt = ST_IDLE;
            ST_IDLE: if (save_go) state_nxt = ST_PROG;
            ST_PROG: if (cnt_zero) state_nxt = ST_IDLE;
            default: state_nxt = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (save_go)
                cnt <= CW'(PROG_CYCLES - 1);
            else if (state == ST_PROG && !cnt_zero)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        load   = 1'b0;
        wr_ok  = 1'b0;
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_LOAD: load = 1'b1;
            ST_IDLE: wr_ok = 1'b1;
            ST_PROG: begin
                busy   = 1'b1;
                commit = cnt_zero;
            end
            default: load = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfgnv_regs.sv
module cfgnv_regs
    import cfgnv_pkg::*;
#(
    parameter logic       VARIANT  = 1'b1,
    parameter logic [2:0] REVISION = 3'd2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      wr_ok,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [NV_BYTES-1:0][7:0]  nv_img,
    input  logic                      busy,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [7:0]                rd_data,
    output logic [NV_BYTES-1:0][7:0]  vol_img
);

    localparam logic [3:0] VENDOR = 4'h1;

    byte_t vol [NV_BYTES];

    for (genvar i = 0; i < NV_BYTES; i++) begin : g_byte
        localparam byte_t MASK = wr_mask(i);
        localparam byte_t STKY = sticky_mask(i);
        logic hit;
        assign hit = wr_ok && wr_en && (wr_addr == ADDR_W'(i + 1));

        always_ff @(posedge clk) begin
            if (!rst_n)
                vol[i] <= nv_default(i);
            else if (load)
                vol[i] <= nv_img[i];
            else if (hit)
                vol[i] <= (vol[i] & ~MASK) | (wr_data & MASK) | (wr_data & STKY);
        end

        assign vol_img[i] = vol[i];
    end

    always_comb begin
        unique case (rd_addr)
            A_ID:    rd_data = {VARIANT, REVISION, VENDOR};
            A_CTRL:  rd_data = {1'b0, busy, vol[0][5:0]};
            A_OUT1:  rd_data = vol[1];
            A_DIVL:  rd_data = vol[2];
            A_SEL:   rd_data = vol[3];
            A_CAP:   rd_data = vol[4];
            A_BCNT:  rd_data = {vol[5][7:1], 1'b0};
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/cfgnv_array.sv
module cfgnv_array
    import cfgnv_pkg::*;
(
    input  logic                      clk,
    input  logic                      nv_blank_n,
    input  logic                      commit,
    input  logic [NV_BYTES-1:0][7:0]  vol_img,
    output logic [NV_BYTES-1:0][7:0]  nv_img
);

    byte_t nv [NV_BYTES];

    for (genvar i = 0; i < NV_BYTES; i++) begin : g_cell
        localparam byte_t KEEP = store_mask(i);

        always_ff @(posedge clk) begin
            if (!nv_blank_n)
                nv[i] <= nv_default(i);
            else if (commit)
                nv[i] <= vol_img[i] & KEEP;
        end

        assign nv_img[i] = nv[i];
    end

endmodule

// File: rtl/cfgnv_bank.sv
module cfgnv_bank
    import cfgnv_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 16,
    parameter logic        VARIANT     = 1'b1,
    parameter logic [2:0]  REVISION    = 3'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nv_blank_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        locked,
    output logic        pwrdn,
    output logic [6:0]  blk_count
);

    logic                     load_w;
    logic                     wr_ok_w;
    logic                     busy_w;
    logic                     commit_w;
    logic [NV_BYTES-1:0][7:0] vol_img;
    logic [NV_BYTES-1:0][7:0] nv_img;

    cfgnv_fsm #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .save_bit  (wr_data[SAVE_BIT]),
        .nv_locked (nv_img[0][LOCK_BIT]),
        .load      (load_w),
        .wr_ok     (wr_ok_w),
        .busy      (busy_w),
        .commit    (commit_w)
    );

    cfgnv_regs #(
        .VARIANT  (VARIANT),
        .REVISION (REVISION)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .wr_ok   (wr_ok_w),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .nv_img  (nv_img),
        .busy    (busy_w),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .vol_img (vol_img)
    );

    cfgnv_array u_arr (
        .clk        (clk),
        .nv_blank_n (nv_blank_n),
        .commit     (commit_w),
        .vol_img    (vol_img),
        .nv_img     (nv_img)
    );

    assign busy      = busy_w;
    assign locked    = nv_img[0][LOCK_BIT];
    assign pwrdn     = vol_img[0][PWDN_BIT];
    assign blk_count = vol_img[5][7:1];

endmodule

// File: rtl/cfgnv_chk.sv
module cfgnv_chk #(
    parameter int unsigned PROG_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nv_blank_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       busy,
    input  logic       locked,
    input  logic       pwrdn,
    input  logic [6:0] blk_count
);

    logic ready;
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        ready <= rst_n;
        if (!rst_n || !busy)
            busy_run <= 0;
        else
            busy_run <= busy_run + 1;
    end

    // R4
    save_start_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_blank_n)
        (ready && wr_en && wr_addr == 4'd6 && wr_data[0] && !busy && !locked) |=> busy);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < PROG_CYCLES));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(blk_count) && $stable(pwrdn)));

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!nv_blank_n)
        locked |=> locked);

    // R8
    lock_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_blank_n)
        (locked && !busy) |=> !busy);

endmodule

bind cfgnv_bank cfgnv_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_blank_n (nv_blank_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .locked     (locked),
    .pwrdn      (pwrdn),
    .blk_count  (blk_count)
);

// File: tb/cfgnv_bank_test.sv
`timescale 1ns/1ps
module cfgnv_bank_test;

    localparam int unsigned P = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_blank_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, locked, pwrdn;
    logic [6:0] blk_count;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cfgnv_bank #(.PROG_CYCLES(P), .VARIANT(1'b1), .REVISION(3'd2)) uut (
        .clk(clk), .rst_n(rst_n), .nv_blank_n(nv_blank_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .locked(locked), .pwrdn(pwrdn), .blk_count(blk_count)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #2;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rst_pulse(input bit wr_in_load);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        if (wr_in_load) begin
            wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h00;
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_save(input string req);
        logic [7:0] v;
        wr(4'd6, {blk_count, 1'b1});
        check({req, " busy after request"}, {7'd0, busy}, 8'h01);
        rd(4'd1, v);
        check({req, " busy bit in reg1"}, {7'd0, v[6]}, 8'h01);
        rd(4'd6, v);
        check({req, " save bit reads 0"}, {7'd0, v[0]}, 8'h00);
        idle(P - 1);
        check({req, " busy in last window cycle"}, {7'd0, busy}, 8'h01);
        idle(1);
        check({req, " busy ends after window"}, {7'd0, busy}, 8'h00);
    endtask

    task automatic t_defaults;
        logic [7:0] v;
        logic [7:0] exp [6] = '{8'h00, 8'hB4, 8'h01, 8'h02, 8'h50, 8'hA0};
        for (int i = 0; i < 6; i++) begin
            rd(4'(i + 1), v);
            check($sformatf("R2 default addr %0d", i + 1), v, exp[i]);
        end
        check("R9 default blk_count", {1'b0, blk_count}, 8'h50);
        check("R2 busy idle", {7'd0, busy}, 8'h00);
        check("R8 not locked", {7'd0, locked}, 8'h00);
    endtask

    task automatic t_id;
        logic [7:0] v;
        rd(4'd0, v);
        check("R1 id value", v, 8'hA1);
        wr(4'd0, 8'h00);
        rd(4'd0, v);
        check("R1 id after write", v, 8'hA1);
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        wr(4'd1, 8'hFF);
        rd(4'd1, v);
        check("R3 reg1 bit7 zero, lock set too", v, 8'h3F);
        wr(4'd5, 8'hFF);
        rd(4'd5, v);
        check("R3 reg5 low bits zero", v, 8'hF8);
        for (int a = 7; a < 16; a++) begin
            wr(4'(a), 8'hFF);
            rd(4'(a), v);
            check($sformatf("R3 addr %0d reads 0", a), v, 8'h00);
        end
    endtask

    task automatic t_pwrdn_count;
        logic [7:0] v;
        wr(4'd1, 8'h1B);
        check("R7 pwrdn output set", {7'd0, pwrdn}, 8'h01);
        wr(4'd6, 8'h24);
        check("R9 blk_count follows", {1'b0, blk_count}, 8'h12);
        rd(4'd6, v);
        check("R9 reg6 readback", v, 8'h24);
    endtask

    task automatic t_save_reload;
        logic [7:0] v;
        wr(4'd2, 8'h5A);
        wr(4'd3, 8'hC3);
        wr(4'd4, 8'h81);
        wr(4'd5, 8'hF8);
        run_save("R4");
        wr(4'd2, 8'h00);
        check("R7 pwrdn before reload", {7'd0, pwrdn}, 8'h01);
        rst_pulse(1'b1);
        rd(4'd1, v); check("R7 pwrdn stored as 0", v, 8'h0B);
        check("R7 pwrdn port after reload", {7'd0, pwrdn}, 8'h00);
        rd(4'd2, v); check("R6 reg2 reloaded", v, 8'h5A);
        rd(4'd3, v); check("R10 write in load ignored", v, 8'hC3);
        rd(4'd4, v); check("R6 reg4 reloaded", v, 8'h81);
        rd(4'd5, v); check("R6 reg5 reloaded", v, 8'hF8);
        rd(4'd6, v); check("R6 reg6 reloaded", v, 8'h24);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        wr(4'd6, 8'h25);
        check("R4 busy started", {7'd0, busy}, 8'h01);
        wr(4'd2, 8'h11);
        wr(4'd6, 8'h01);
        rd(4'd2, v);
        check("R5 write dropped in busy", v, 8'h5A);
        check("R5 count unchanged in busy", {1'b0, blk_count}, 8'h12);
        idle(P);
        check("R5 second request rejected", {7'd0, busy}, 8'h00);
        idle(1);
        check("R5 no later window", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        wr(4'd1, 8'h2B);
        wr(4'd1, 8'h0B);
        rd(4'd1, v);
        check("R8 lock bit sticky", v, 8'h2B);
        check("R8 not locked before save", {7'd0, locked}, 8'h00);
        run_save("R8");
        check("R8 locked after save", {7'd0, locked}, 8'h01);
        wr(4'd6, 8'h25);
        check("R8 save rejected when locked", {7'd0, busy}, 8'h00);
        rst_pulse(1'b0);
        rd(4'd1, v);
        check("R8 lock survives reset", v, 8'h2B);
        check("R8 locked port after reset", {7'd0, locked}, 8'h01);
    endtask

    initial begin
        idle(3);
        nv_blank_n = 1'b1;
        rst_n = 1'b1;
        idle(2);
        t_defaults();
        t_id();
        t_reserved();
        rst_pulse(1'b0);
        t_pwrdn_count();
        t_save_reload();
        t_busy_ignore();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule